// File: doc/BRIEF.md
# Radix Vector Carry Propagator

This block adds two vectors of N digits element by element, where every digit is held in a W-bit slot and the arithmetic base is a run-time radix anywhere from 2 up to 2^W. The result is one multi-precision number in that radix. Each element forms its raw sum with no incoming carry. It then raises a generate bit when that sum already overflows the radix, or a propagate bit when the sum sits exactly one below the radix.

The generate bits and the propagate bits are packed into two N-bit integers. A single wide addition followed by an XOR turns them into every inter-element carry at once, with the external carry-in entering at the least significant element. Each element then folds its carry back into its raw sum modulo the radix.

A one-cycle start strobe captures the operands. One clock later the digits, the carry leaving the top element and a flag that tells whether any element passed a carry on are registered, and done pulses. The outputs hold until the next start.

Top module: `radix_carry_vec`

## Requirements
- R1: While reset (rst_n low) is applied and after it is released, done_o, carry_o, prop_any_o and every bit of sum_o are 0 until the first start.
- R2: A start_i pulse sampled high on a clock edge makes done_o high for exactly the following cycle. done_o is never high without start_i having been high on the previous edge.
- R3: Output digit i, at bits [i*W +: W] of sum_o, equals (A_i + B_i + c_i) mod radix. Here A_i and B_i sit at the same bit positions of a_i and b_i, c_0 is carry_i, and c_(i+1) is 1 exactly when A_i + B_i + c_i >= radix. This matches a digit-by-digit ripple add.
- R4: carry_o equals c_N, the carry leaving element N-1.
- R5: An element whose raw sum equals radix-1 passes its incoming carry on unchanged. A carry can therefore travel across a whole chain of such elements within the single registered cycle.
- R6: prop_any_o is 1 when at least one of c_1..c_N is 1 and 0 when none is. Because c_N is among them, carry_o high implies prop_any_o high.
- R7: The radix input radix_i is W+1 bits wide. The values 2 and 2^W are both handled correctly, and every digit of sum_o is less than the radix.
- R8: While start_i is low, changes on a_i, b_i, radix_i and carry_i have no effect on sum_o, carry_o or prop_any_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture operands and compute |
| a_i | input | N*W | First digit vector, digit i at [i*W +: W] |
| b_i | input | N*W | Second digit vector, same packing |
| radix_i | input | W+1 | Radix, 2 to 2^W |
| carry_i | input | 1 | Carry into element 0 |
| sum_o | output | N*W | Result digits, same packing |
| carry_o | output | 1 | Carry out of element N-1 |
| prop_any_o | output | 1 | High when any element produced a carry |
| done_o | output | 1 | One-cycle pulse, result valid |

## Verification
The bench builds the block with its defaults: eight digits of eight bits, using the packed carry resolver. With W at 8 the radix can reach 256, so the full-width case where the radix equals 2^W is exercised next to radix 2, decimal and odd radices. Eight elements give a propagate chain long enough to show a single carry crossing the entire vector in one step. A pseudo-random sweep over radices from 2 to 256 compares every digit, the carry-out and the flag against a ripple model.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

   typedef enum int {
      CARRY_PACKED = 0,
      CARRY_RIPPLE = 1
   } carry_style_e;

   // Raw per-element sum needs one bit more than a digit.
   function automatic int raw_width(input int w);
      return w + 1;
   endfunction

endpackage

// File: rtl/rcv_digit_cell.sv
module rcv_digit_cell #(
   parameter int W  = 8,
   localparam int RW = rcv_pkg::raw_width(W)
) (
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   input  logic [RW-1:0] radix,
   output logic [RW-1:0] raw,
   output logic          gen,
   output logic          prp
);
   logic [RW-1:0] lim;

   always_comb begin
      raw = {1'b0, a} + {1'b0, b};
      lim = radix - RW'(1);
      gen = (raw > lim);
      prp = (raw == lim);
   end
endmodule

// File: rtl/rcv_carry_resolve.sv
module rcv_carry_resolve #(
   parameter int N = 8,
   parameter rcv_pkg::carry_style_e STYLE = rcv_pkg::CARRY_PACKED
) (
   input  logic [N-1:0] p,
   input  logic [N-1:0] g,
   input  logic         cin,
   output logic [N:0]   cvec
);
   generate
      if (STYLE == rcv_pkg::CARRY_PACKED) begin : g_packed
         logic [N:0] s;
         always_comb begin
            s    = {1'b0, p | g} + {1'b0, g} + (N+1)'(cin);
            cvec = s ^ {1'b0, p};
         end
      end else begin : g_ripple
         always_comb begin
            cvec[0] = cin;
            for (int i = 0; i < N; i++) begin
               cvec[i+1] = g[i] | (p[i] & cvec[i]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rcv_digit_fix.sv
module rcv_digit_fix #(
   parameter int W  = 8,
   localparam int RW = rcv_pkg::raw_width(W)
) (
   input  logic [RW-1:0] raw,
   input  logic          cin,
   input  logic [RW-1:0] radix,
   output logic [W-1:0]  digit
);
   logic [RW-1:0] t;

   always_comb begin
      t = raw + {{(RW-1){1'b0}}, cin};
      if (t >= radix) digit = W'(t - radix);
      else            digit = W'(t);
   end
endmodule

// File: rtl/radix_carry_vec.sv
module radix_carry_vec #(
   parameter int N = 8,
   parameter int W = 8,
   parameter rcv_pkg::carry_style_e STYLE = rcv_pkg::CARRY_PACKED,
   localparam int RW = rcv_pkg::raw_width(W),
   localparam int VW = N * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [VW-1:0] a_i,
   input  logic [VW-1:0] b_i,
   input  logic [RW-1:0] radix_i,
   input  logic          carry_i,
   output logic [VW-1:0] sum_o,
   output logic          carry_o,
   output logic          prop_any_o,
   output logic          done_o
);
   if (N < 1) begin : g_bad_n
      $error("radix_carry_vec: N must be at least 1");
   end
   if (W < 1 || W > 30) begin : g_bad_w
      $error("radix_carry_vec: W must be in 1..30");
   end

   logic [N-1:0]  gen_v;
   logic [N-1:0]  prp_v;
   logic [N:0]    cvec;
   logic [VW-1:0] digits;

   for (genvar i = 0; i < N; i++) begin : g_elem
      logic [RW-1:0] raw;

      rcv_digit_cell #(.W(W)) u_cell (
         .a     (a_i[i*W +: W]),
         .b     (b_i[i*W +: W]),
         .radix (radix_i),
         .raw   (raw),
         .gen   (gen_v[i]),
         .prp   (prp_v[i])
      );

      rcv_digit_fix #(.W(W)) u_fix (
         .raw   (raw),
         .cin   (cvec[i]),
         .radix (radix_i),
         .digit (digits[i*W +: W])
      );
   end

   rcv_carry_resolve #(.N(N), .STYLE(STYLE)) u_resolve (
      .p    (prp_v),
      .g    (gen_v),
      .cin  (carry_i),
      .cvec (cvec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_o      <= '0;
         carry_o    <= 1'b0;
         prop_any_o <= 1'b0;
         done_o     <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            sum_o      <= digits;
            carry_o    <= cvec[N];
            prop_any_o <= |cvec[N:1];
         end
      end
   end
endmodule

// File: rtl/rcv_chk.sv
module rcv_chk #(
   parameter int N = 8,
   parameter int W = 8,
   localparam int RW = W + 1,
   localparam int VW = N * W
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic [RW-1:0] radix_i,
   input logic [VW-1:0] sum_o,
   input logic          carry_o,
   input logic          prop_any_o,
   input logic          done_o
);
   function automatic bit digits_ok(input logic [VW-1:0] v, input logic [RW-1:0] r);
      bit ok = 1'b1;
      for (int i = 0; i < N; i++) begin
         if ({1'b0, v[i*W +: W]} >= r) ok = 1'b0;
      end
      return ok;
   endfunction

   AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o); // R2
   AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(start_i)); // R2
   AST_CARRY_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      carry_o |-> prop_any_o); // R6
   AST_DIGIT_BELOW_RADIX: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> digits_ok(sum_o, $past(radix_i))); // R7
   AST_HOLD_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(sum_o) && $stable(carry_o) && $stable(prop_any_o))); // R8
endmodule

bind radix_carry_vec rcv_chk #(.N(N), .W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .radix_i    (radix_i),
   .sum_o      (sum_o),
   .carry_o    (carry_o),
   .prop_any_o (prop_any_o),
   .done_o     (done_o)
);

// File: tb/sim_radix_carry_vec.sv
module sim_radix_carry_vec;
   localparam int N  = 8;
   localparam int W  = 8;
   localparam int RW = W + 1;
   localparam int VW = N * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [VW-1:0] a_i = '0;
   logic [VW-1:0] b_i = '0;
   logic [RW-1:0] radix_i = RW'(10);
   logic          carry_i = 1'b0;
   logic [VW-1:0] sum_o;
   logic          carry_o;
   logic          prop_any_o;
   logic          done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   int unsigned lcg = 32'h1234_5678;

   always #10 clk = ~clk;

   radix_carry_vec #(.N(N), .W(W)) u0 (
      .clk, .rst_n, .start_i, .a_i, .b_i, .radix_i, .carry_i,
      .sum_o, .carry_o, .prop_any_o, .done_o
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   function automatic int unsigned next_rand();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg >> 8;
   endfunction

   // Ripple reference and one full start/check cycle.
   task automatic run(input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input int r, input bit cin, input string req);
      logic [VW-1:0] exp_sum;
      int c;
      bit any;
      c = cin;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         int s;
         s = int'(a[i*W +: W]) + int'(b[i*W +: W]) + c;
         if (s >= r) begin
            exp_sum[i*W +: W] = W'(s - r);
            c = 1;
         end else begin
            exp_sum[i*W +: W] = W'(s);
            c = 0;
         end
         if (c != 0) any = 1'b1;
      end
      @(negedge clk);
      a_i = a; b_i = b; radix_i = RW'(r); carry_i = cin; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b1, "R2", "done after start", VW'(done_o), VW'(1));
      chk(sum_o == exp_sum, req, "digits (R3)", sum_o, exp_sum);
      chk(carry_o == c[0], "R4", "carry out", VW'(carry_o), VW'(c[0]));
      chk(prop_any_o == any, "R6", "propagation flag", VW'(prop_any_o), VW'(any));
      @(negedge clk);
      chk(done_o == 1'b0, "R2", "done single pulse", VW'(done_o), VW'(0));
   endtask

   function automatic logic [VW-1:0] fill(input int d);
      logic [VW-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = W'(d);
      return v;
   endfunction

   task automatic t_reset();
      chk(done_o == 1'b0, "R1", "done in reset", VW'(done_o), VW'(0));
      chk(sum_o == '0, "R1", "sum in reset", sum_o, '0);
      chk(carry_o == 1'b0, "R1", "carry in reset", VW'(carry_o), VW'(0));
      chk(prop_any_o == 1'b0, "R1", "flag in reset", VW'(prop_any_o), VW'(0));
   endtask

   task automatic t_decimal();
      logic [VW-1:0] a, b;
      // digit 0 is least significant: 5+7 carries, 4+5 = 9 propagates it
      a = '0; b = '0;
      a[0*W +: W] = 8'd5; b[0*W +: W] = 8'd7;
      a[1*W +: W] = 8'd4; b[1*W +: W] = 8'd5;
      a[2*W +: W] = 8'd3; b[2*W +: W] = 8'd1;
      a[7*W +: W] = 8'd9; b[7*W +: W] = 8'd9;
      run(a, b, 10, 1'b0, "R3");
      run(a, b, 10, 1'b1, "R3");
   endtask

   task automatic t_chain();
      // every element sums to radix-1; the carry-in crosses all eight (R5)
      run(fill(4), fill(5), 10, 1'b1, "R5");
      run(fill(4), fill(5), 10, 1'b0, "R5");
      run(fill(200), fill(55), 256, 1'b1, "R5");
   endtask

   task automatic t_radix_edges();
      run(fill(255), fill(255), 256, 1'b1, "R7");
      run(fill(1), fill(0), 2, 1'b1, "R7");
      run(fill(1), fill(1), 2, 1'b0, "R7");
      run(fill(6), fill(6), 7, 1'b0, "R7");
   endtask

   task automatic t_no_carry();
      run(fill(1), fill(2), 10, 1'b0, "R6");
      run(fill(0), fill(0), 256, 1'b1, "R6");
   endtask

   task automatic t_hold();
      logic [VW-1:0] s0;
      logic c0, f0;
      run(fill(9), fill(3), 10, 1'b1, "R3");
      s0 = sum_o; c0 = carry_o; f0 = prop_any_o;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         a_i = fill(k + 1); b_i = fill(k + 2); radix_i = RW'(5); carry_i = ~carry_i;
      end
      @(negedge clk);
      chk(sum_o == s0, "R8", "sum held", sum_o, s0);
      chk(carry_o == c0, "R8", "carry held", VW'(carry_o), VW'(c0));
      chk(prop_any_o == f0, "R8", "flag held", VW'(prop_any_o), VW'(f0));
      chk(done_o == 1'b0, "R8", "no done without start", VW'(done_o), VW'(0));
   endtask

   task automatic t_sweep();
      for (int n = 0; n < 40; n++) begin
         logic [VW-1:0] a, b;
         int r;
         r = 2 + int'(next_rand() % 255);
         for (int i = 0; i < N; i++) begin
            a[i*W +: W] = W'(next_rand() % r);
            b[i*W +: W] = W'(next_rand() % r);
         end
         run(a, b, r, next_rand() % 2 == 1, "R3");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_decimal();
      t_chain();
      t_radix_edges();
      t_no_carry();
      t_hold();
      t_sweep();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule